// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional

This block keeps the single reservation that a core needs to run load-linked / store-conditional sequences. A load-linked request records the cache-block tag of its address in a link register and marks it valid. The reservation is dropped when a coherence invalidation or another agent's write touches the same cache block, when an interrupt or context switch is signalled, or when any store-conditional is handled.

A store-conditional passes only if a valid reservation exists for the same cache block and nothing drops it in that cycle. The verdict appears one cycle after the request. On a pass the store goes out on a memory write port in that same cycle. On a fail nothing is written.

The block size, the address and data widths and the number of snooped write ports are parameters. The checks on them run at elaboration.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset no reservation exists. A store-conditional issued before any load-linked fails, and that includes a store-conditional to address zero.
- R2: A store-conditional fails with no memory write when its cache block differs from the reserved one.
- R3: A store-conditional passes when the last load-linked reserved the same 64-byte block. Address bits [5:0] are ignored in the comparison, and idle cycles in between do not matter.
- R4: An invalidation (`inv_vld`) whose address falls in the reserved block drops the reservation. An invalidation of any other block leaves the reservation in place.
- R5: A write by another agent on any snoop port (`snp_vld[i]`, address in slice i of `snp_addr`) to the reserved block drops the reservation. A write to another block does not.
- R6: `irq_evt` high drops the reservation.
- R7: Every store-conditional drops the reservation, whether it passes or fails, so a second store-conditional with no new load-linked fails.
- R8: A new load-linked replaces the old reservation. A store-conditional to the old block then fails, and one to the new block passes.
- R9: `sc_done` is high exactly in the cycle after each `sc_req` and in no other cycle. `sc_fail` is 0 for a pass and 1 for a fail. `mem_wr_en` is high only in that result cycle and only on a pass, and it carries the store's address and data.
- R10: Same-cycle rules:
  - A drop event together with a store-conditional makes the store-conditional fail.
  - `irq_evt` together with a load-linked leaves no reservation.
  - A load-linked together with a store-conditional: the store-conditional is judged on the old reservation, and the new reservation is kept.
  - A load-linked together with a snoop to its own block keeps the new reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_req | input | 1 | Load-linked request |
| ll_addr | input | ADDR_W | Load-linked byte address |
| sc_req | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| sc_wdata | input | DATA_W | Store-conditional data |
| inv_vld | input | 1 | Coherence invalidation strobe |
| inv_addr | input | ADDR_W | Invalidated address |
| snp_vld | input | N_SNOOP | Other-agent write strobes, one per port |
| snp_addr | input | N_SNOOP*ADDR_W | Other-agent write addresses, port i in slice i |
| irq_evt | input | 1 | Interrupt or context switch |
| sc_done | output | 1 | Store-conditional result valid |
| sc_fail | output | 1 | 0 = pass, 1 = fail |
| mem_wr_en | output | 1 | Memory write strobe (pass only) |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |

## Verification
Every store-conditional result, along with the memory write it permits, is due one cycle after the request. The link register updates at the same edge, so a drop or replace event influences a store-conditional in the following cycle, or in the same cycle through the R10 rules. The driver stamps each expected result with the cycle count at which it should appear. The monitor samples 2 ns after each rising edge, compares that stamp against the current count, and also checks that `mem_wr_en` stays low in every cycle that carries no result.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   // Operation applied to the link register at the next edge
   typedef enum logic [1:0] {
      RSV_HOLD = 2'd0,
      RSV_LOAD = 2'd1,
      RSV_DROP = 2'd2
   } rsv_op_e;

   function automatic int unsigned blk_ofs_bits(input int unsigned blk_bytes);
      return $clog2(blk_bytes);
   endfunction

endpackage

// File: rtl/llsc_blk_match.sv
module llsc_blk_match #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 6,
   localparam int TAG_W = ADDR_W - OFS_W
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              tag_vld,
   input  logic [TAG_W-1:0]  tag,
   output logic              hit
);

   logic [TAG_W-1:0] addr_tag;

   assign addr_tag = addr[ADDR_W-1:OFS_W];
   assign hit      = en && tag_vld && (addr_tag == tag);

endmodule

// File: rtl/llsc_link_reg.sv
module llsc_link_reg
   import llsc_pkg::*;
#(
   parameter int TAG_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rsv_op_e          op,
   input  logic [TAG_W-1:0] ld_tag,
   output logic             vld_q,
   output logic [TAG_W-1:0] tag_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         tag_q <= '0;
      end else begin
         unique case (op)
            RSV_LOAD: begin
               vld_q <= 1'b1;
               tag_q <= ld_tag;
            end
            RSV_DROP: begin
               vld_q <= 1'b0;
               tag_q <= '0;
            end
            default: begin
               vld_q <= vld_q;
               tag_q <= tag_q;
            end
         endcase
      end
   end

endmodule

// File: rtl/llsc_result_stage.sv
module llsc_result_stage #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter bit ZERO_IDLE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sc_req,
   input  logic              pass,
   input  logic [ADDR_W-1:0] sc_addr,
   input  logic [DATA_W-1:0] sc_wdata,
   output logic              sc_done,
   output logic              sc_fail,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data
);

   logic              done_q;
   logic              fail_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         done_q <= sc_req;
         fail_q <= sc_req && !pass;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (sc_req && pass) begin
         addr_q <= sc_addr;
         data_q <= sc_wdata;
      end
   end

   assign sc_done   = done_q;
   assign sc_fail   = fail_q;
   assign mem_wr_en = done_q && !fail_q;

   generate
      if (ZERO_IDLE) begin : g_zero_idle
         assign mem_wr_addr = mem_wr_en ? addr_q : '0;
         assign mem_wr_data = mem_wr_en ? data_q : '0;
      end else begin : g_hold_bus
         assign mem_wr_addr = addr_q;
         assign mem_wr_data = data_q;
      end
   endgenerate

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
   import llsc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 64,
   parameter int BLK_BYTES = 64,
   parameter int N_SNOOP   = 2,
   parameter bit ZERO_IDLE = 1'b1,
   localparam int OFS_W    = blk_ofs_bits(BLK_BYTES),
   localparam int TAG_W    = ADDR_W - OFS_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ll_req,
   input  logic [ADDR_W-1:0]         ll_addr,
   input  logic                      sc_req,
   input  logic [ADDR_W-1:0]         sc_addr,
   input  logic [DATA_W-1:0]         sc_wdata,
   input  logic                      inv_vld,
   input  logic [ADDR_W-1:0]         inv_addr,
   input  logic [N_SNOOP-1:0]        snp_vld,
   input  logic [N_SNOOP*ADDR_W-1:0] snp_addr,
   input  logic                      irq_evt,
   output logic                      sc_done,
   output logic                      sc_fail,
   output logic                      mem_wr_en,
   output logic [ADDR_W-1:0]         mem_wr_addr,
   output logic [DATA_W-1:0]         mem_wr_data
);

   // Elaboration-time parameter checks
   generate
      if ((BLK_BYTES < 2) || ((BLK_BYTES & (BLK_BYTES - 1)) != 0)) begin : g_bad_blk
         $fatal(1, "BLK_BYTES must be a power of two of at least 2");
      end
      if (OFS_W >= ADDR_W) begin : g_bad_addr
         $fatal(1, "ADDR_W must exceed the block offset width");
      end
      if (N_SNOOP < 1) begin : g_bad_snoop
         $fatal(1, "N_SNOOP must be at least 1");
      end
      if (DATA_W < 8) begin : g_bad_data
         $fatal(1, "DATA_W must be at least 8");
      end
   endgenerate

   logic             rsv_vld;
   logic [TAG_W-1:0] rsv_tag;
   logic             sc_hit;
   logic             inv_hit;
   logic [N_SNOOP-1:0] snp_hit;
   logic             drop_evt;
   logic             sc_pass;
   rsv_op_e          rsv_op;

   llsc_blk_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_sc_match (
      .en      (sc_req),
      .addr    (sc_addr),
      .tag_vld (rsv_vld),
      .tag     (rsv_tag),
      .hit     (sc_hit)
   );

   llsc_blk_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_inv_match (
      .en      (inv_vld),
      .addr    (inv_addr),
      .tag_vld (rsv_vld),
      .tag     (rsv_tag),
      .hit     (inv_hit)
   );

   generate
      for (genvar i = 0; i < N_SNOOP; i++) begin : g_snoop
         llsc_blk_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_snp_match (
            .en      (snp_vld[i]),
            .addr    (snp_addr[i*ADDR_W +: ADDR_W]),
            .tag_vld (rsv_vld),
            .tag     (rsv_tag),
            .hit     (snp_hit[i])
         );
      end
   endgenerate

   assign drop_evt = irq_evt || inv_hit || (|snp_hit);
   assign sc_pass  = sc_hit && !drop_evt;

   always_comb begin
      if (irq_evt)
         rsv_op = RSV_DROP;
      else if (ll_req)
         rsv_op = RSV_LOAD;
      else if (sc_req || drop_evt)
         rsv_op = RSV_DROP;
      else
         rsv_op = RSV_HOLD;
   end

   llsc_link_reg #(.TAG_W(TAG_W)) u_link (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (rsv_op),
      .ld_tag (ll_addr[ADDR_W-1:OFS_W]),
      .vld_q  (rsv_vld),
      .tag_q  (rsv_tag)
   );

   llsc_result_stage #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .ZERO_IDLE (ZERO_IDLE)
   ) u_result (
      .clk         (clk),
      .rst_n       (rst_n),
      .sc_req      (sc_req),
      .pass        (sc_pass),
      .sc_addr     (sc_addr),
      .sc_wdata    (sc_wdata),
      .sc_done     (sc_done),
      .sc_fail     (sc_fail),
      .mem_wr_en   (mem_wr_en),
      .mem_wr_addr (mem_wr_addr),
      .mem_wr_data (mem_wr_data)
   );

endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 64,
   parameter int BLK_BYTES = 64,
   parameter int N_SNOOP   = 2,
   localparam int OFS_W    = $clog2(BLK_BYTES)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ll_req,
   input logic [ADDR_W-1:0]         sc_addr,
   input logic                      sc_req,
   input logic [DATA_W-1:0]         sc_wdata,
   input logic                      inv_vld,
   input logic [ADDR_W-1:0]         inv_addr,
   input logic [N_SNOOP-1:0]        snp_vld,
   input logic [N_SNOOP*ADDR_W-1:0] snp_addr,
   input logic                      irq_evt,
   input logic                      sc_done,
   input logic                      sc_fail,
   input logic                      mem_wr_en,
   input logic [ADDR_W-1:0]         mem_wr_addr,
   input logic [DATA_W-1:0]         mem_wr_data
);

   a_r9_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      sc_req |=> sc_done);

   a_r9_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_req |=> !sc_done);

   a_r9_write_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (sc_done && !sc_fail));

   a_r9_pass_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_done && !sc_fail) |-> mem_wr_en);

   a_r9_write_payload: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (mem_wr_addr == $past(sc_addr) && mem_wr_data == $past(sc_wdata)));

   a_r6_irq_fails_sc: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_req && irq_evt) |=> sc_fail);

   a_r4_inval_same_blk: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_req && inv_vld && inv_addr[ADDR_W-1:OFS_W] == sc_addr[ADDR_W-1:OFS_W])
      |=> sc_fail);

   a_r5_snoop0_same_blk: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_req && snp_vld[0] && snp_addr[ADDR_W-1:OFS_W] == sc_addr[ADDR_W-1:OFS_W])
      |=> sc_fail);

   a_r7_second_sc_fails: assert property (@(posedge clk) disable iff (!rst_n)
      ((sc_req && !ll_req) ##1 sc_req) |=> sc_fail);

endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .BLK_BYTES (BLK_BYTES),
   .N_SNOOP   (N_SNOOP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ll_req      (ll_req),
   .sc_addr     (sc_addr),
   .sc_req      (sc_req),
   .sc_wdata    (sc_wdata),
   .inv_vld     (inv_vld),
   .inv_addr    (inv_addr),
   .snp_vld     (snp_vld),
   .snp_addr    (snp_addr),
   .irq_evt     (irq_evt),
   .sc_done     (sc_done),
   .sc_fail     (sc_fail),
   .mem_wr_en   (mem_wr_en),
   .mem_wr_addr (mem_wr_addr),
   .mem_wr_data (mem_wr_data)
);

// File: tb/llsc_resv_monitor_test.sv
`timescale 1ns/1ps
module llsc_resv_monitor_test;

   localparam int AW = 32;
   localparam int DW = 64;
   localparam int NS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ll_req = 1'b0;
   logic [AW-1:0] ll_addr = '0;
   logic          sc_req = 1'b0;
   logic [AW-1:0] sc_addr = '0;
   logic [DW-1:0] sc_wdata = '0;
   logic          inv_vld = 1'b0;
   logic [AW-1:0] inv_addr = '0;
   logic [NS-1:0] snp_vld = '0;
   logic [NS*AW-1:0] snp_addr = '0;
   logic          irq_evt = 1'b0;
   logic          sc_done;
   logic          sc_fail;
   logic          mem_wr_en;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 1'b0;

   typedef struct {
      logic          fail;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      int            due;
      string         tag;
   } exp_t;

   exp_t sbq[$];

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc <= cyc + 1;

   llsc_resv_monitor #(.ADDR_W(AW), .DATA_W(DW), .BLK_BYTES(64), .N_SNOOP(NS)) uut (
      .clk(clk), .rst_n(rst_n),
      .ll_req(ll_req), .ll_addr(ll_addr),
      .sc_req(sc_req), .sc_addr(sc_addr), .sc_wdata(sc_wdata),
      .inv_vld(inv_vld), .inv_addr(inv_addr),
      .snp_vld(snp_vld), .snp_addr(snp_addr),
      .irq_evt(irq_evt),
      .sc_done(sc_done), .sc_fail(sc_fail),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
      end
   endtask

   task automatic idle_inputs();
      ll_req = 1'b0; sc_req = 1'b0; inv_vld = 1'b0; snp_vld = '0; irq_evt = 1'b0;
   endtask

   task automatic gap();
      @(negedge clk); idle_inputs();
   endtask

   task automatic do_ll(input logic [AW-1:0] a);
      @(negedge clk); idle_inputs();
      ll_req = 1'b1; ll_addr = a;
   endtask

   task automatic do_sc(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic fail, input string tag);
      exp_t e;
      @(negedge clk); idle_inputs();
      sc_req = 1'b1; sc_addr = a; sc_wdata = d;
      e.fail = fail; e.addr = a; e.data = d; e.due = cyc + 1; e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic do_inv(input logic [AW-1:0] a);
      @(negedge clk); idle_inputs();
      inv_vld = 1'b1; inv_addr = a;
   endtask

   task automatic do_snp(input int port, input logic [AW-1:0] a);
      @(negedge clk); idle_inputs();
      snp_vld[port] = 1'b1; snp_addr[port*AW +: AW] = a;
   endtask

   task automatic do_irq();
      @(negedge clk); idle_inputs();
      irq_evt = 1'b1;
   endtask

   // Monitor: pops the scoreboard as results appear
   always @(posedge clk) begin
      #2;
      if (rst_n && !finished) begin
         if (sc_done) begin
            if (sbq.size() == 0) begin
               check("R9 unexpected sc_done", 1, 0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               check({e.tag, " R9 result cycle"}, cyc, e.due);
               check({e.tag, " sc_fail"}, sc_fail, e.fail);
               check({e.tag, " R9 mem_wr_en"}, mem_wr_en, !e.fail);
               if (!e.fail) begin
                  check({e.tag, " R9 mem_wr_addr"}, mem_wr_addr, e.addr);
                  check({e.tag, " R9 mem_wr_data"}, mem_wr_data, e.data);
               end
            end
         end else begin
            check("R9 no write without result", mem_wr_en, 0);
         end
      end
   end

   localparam logic [AW-1:0] A = 32'h1000_0040;
   localparam logic [AW-1:0] B = 32'h2000_0100;

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset sc_done", sc_done, 0);
      check("R1 reset mem_wr_en", mem_wr_en, 0);
      rst_n = 1'b1;
      gap();

      // R1: no reservation after reset, zero address included
      do_sc(32'h0, 64'h11, 1'b1, "R1 zero addr");
      do_sc(A, 64'h12, 1'b1, "R1 no ll");
      gap();

      // R3: same block, different offset, with idle cycles
      do_ll(A); do_sc(A + 32'h38, 64'hA1, 1'b0, "R3 offset");
      do_ll(A + 32'h3F); gap(); gap(); do_sc(A, 64'hA2, 1'b0, "R3 idle gap");

      // R2: other block
      do_ll(A); do_sc(A + 32'h40, 64'hB1, 1'b1, "R2 diff blk");

      // R4: invalidation
      do_ll(A); do_inv(A + 32'h40); do_sc(A, 64'hC1, 1'b0, "R4 other blk inv");
      do_ll(A); do_inv(A + 32'h4); do_sc(A, 64'hC2, 1'b1, "R4 same blk inv");

      // R5: other-agent writes on each port
      do_ll(A); do_snp(1, A + 32'h8); do_sc(A, 64'hD1, 1'b1, "R5 port1 hit");
      do_ll(A); do_snp(0, B); do_sc(A, 64'hD2, 1'b0, "R5 port0 miss");
      do_ll(A); do_snp(0, A); do_sc(A, 64'hD3, 1'b1, "R5 port0 hit");

      // R6: interrupt
      do_ll(A); do_irq(); do_sc(A, 64'hE1, 1'b1, "R6 irq");

      // R7: every sc clears
      do_ll(A); do_sc(A, 64'hF1, 1'b0, "R7 first");
      do_sc(A, 64'hF2, 1'b1, "R7 second");
      do_ll(B); do_sc(A, 64'hF3, 1'b1, "R7 failed first");
      do_sc(B, 64'hF4, 1'b1, "R7 after fail");

      // R8: replacement
      do_ll(A); do_ll(B); do_sc(A, 64'h81, 1'b1, "R8 old blk");
      do_ll(A); do_ll(B); do_sc(B, 64'h82, 1'b0, "R8 new blk");

      // R10: same-cycle rules
      do_ll(A); do_sc(A, 64'h91, 1'b1, "R10 sc+inv"); inv_vld = 1'b1; inv_addr = A;
      do_ll(A); irq_evt = 1'b1; do_sc(A, 64'h92, 1'b1, "R10 ll+irq");
      do_ll(A); do_sc(A, 64'h93, 1'b0, "R10 sc+ll old"); ll_req = 1'b1; ll_addr = B;
      do_sc(B, 64'h94, 1'b0, "R10 sc+ll new");
      do_ll(A); snp_vld[0] = 1'b1; snp_addr[AW-1:0] = A;
      do_sc(A, 64'h95, 1'b0, "R10 ll+snoop");

      repeat (4) gap();
      check("R9 all results seen", sbq.size(), 0);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog R9 act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule